// File: doc/BRIEF.md
# Multi-Mode SPI Master

This block is a full-duplex serial master. For each transaction it exchanges one character with one slave. The host presents the following, all on the same clock cycle as a one-cycle start pulse:

- a transmit word
- a character length between 4 and 16 bits
- the clock idle level
- the clock phase
- the index of the slave to address
- a half-period divider

The block then:

- pulls the chosen slave-select line low;
- toggles the serial clock once per half-period of system clocks, shifting one bit out on the data-out line and one bit in from the data-in line on every serial clock cycle, most significant bit first;
- releases the select line;
- returns the received character, right aligned, together with a one-cycle done pulse.

The protocol has no acknowledge, no addressing and no flow control. The clock idle level and the phase can change from one transfer to the next, so a single master can serve slaves that use different modes. A new start given in the cycle that carries the done pulse is accepted at once, which allows back-to-back characters.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, `busy` and `done` are 0, every `ss_n` line is 1, and both `sclk` and `mosi` are 0.
- R2: From the cycle after an accepted start until the transfer ends, exactly one select line is low: line number `sel_idx`, captured at start. No other select line goes low.
- R3: The effective length L is `char_len` limited to the range 4..16, so values below 4 give 4 and values above 16 give 16. A transfer makes exactly 2L serial clock edges. The L low bits of `tx_word` go out most significant bit first.
- R4: With phase 0, the first data bit is on `mosi` before the first edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With phase 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. A leading edge is one that leaves the idle level.
- R5: `sclk` takes the `cpol` level captured at start, stays at that level while no transfer is running, and ends each transfer at that level.
- R6: Consecutive serial clock edges are exactly `half_div`+1 system clocks apart. The select line falls at least one half-period before the first edge and rises at least one half-period after the last edge.
- R7: At the end of a transfer, `done` is high for exactly one cycle. `rx_word` then holds the L received bits, right aligned, with its upper bits zero.
- R8: A change to `tx_word`, `char_len`, `cpol`, `cpha`, `sel_idx` or `half_div` while `busy` is high, or a start pulse in that time, has no effect on the running transfer and starts no new one.
- R9: A start that is high in the cycle where `done` is high is accepted, and `busy` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer; accepted only when not busy |
| tx_word | input | MAX_LEN | Character to send, right aligned |
| char_len | input | LEN_W | Requested character length in bits |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| sel_idx | input | SEL_W | Index of the select line to drive |
| half_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the transfer ends |
| rx_word | output | MAX_LEN | Received character, right aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data from the master |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | NUM_SEL | Active-low slave selects, one per slave |

## Verification
Two situations are hard to reach from the ports:

- inputs that change in the middle of a transfer;
- a start that lands in the exact cycle of the done pulse.

For the first, the stimulus counts falling clock edges after an accepted start. It then flips every configuration input, changes the transmit word and pulses start while the shift is still running. The checks then confirm that the behavioural slave still saw the original character, length, mode and select line. For the second, start is held high through the whole first transfer, so it is present on the edge where the block returns to idle. The bench then checks that the select line goes high for only one cycle before the second character begins.

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int NUM_SEL = 4,
  parameter int MAX_LEN = 16,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  localparam int SEL_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [MAX_LEN-1:0] tx_word,
  input  logic [LEN_W-1:0]   char_len,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [SEL_W-1:0]   sel_idx,
  input  logic [DIV_W-1:0]   half_div,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] rx_word,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] ss_n
);
  localparam int EDGE_W = LEN_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL} st_t;

  st_t                st;
  logic [DIV_W-1:0]   cnt, div_r;
  logic [LEN_W-1:0]   len_r, len_in;
  logic               cpol_r, cpha_r, sclk_r, done_r;
  logic [SEL_W-1:0]   sel_r;
  logic [EDGE_W-1:0]  edge_n;
  logic [MAX_LEN:0]   tx_sh;
  logic [MAX_LEN-1:0] rx_sh, rx_r, aligned;
  logic               tick, sample_now, last_edge;

  assign len_in = (char_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) :
                  (char_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : char_len;
  assign aligned    = tx_word << (LEN_W'(MAX_LEN) - len_in);
  assign tick       = (cnt == '0);
  assign sample_now = cpha_r ? edge_n[0] : ~edge_n[0];
  assign last_edge  = (edge_n == ({len_r, 1'b0} - EDGE_W'(1)));

  assign busy    = (st != S_IDLE);
  assign done    = done_r;
  assign rx_word = rx_r;
  assign sclk    = sclk_r;
  assign mosi    = tx_sh[MAX_LEN];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign ss_n[i] = ~(busy && (sel_r == SEL_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      div_r  <= '0;
      len_r  <= LEN_W'(MIN_LEN);
      cpol_r <= 1'b0;
      cpha_r <= 1'b0;
      sel_r  <= '0;
      edge_n <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_r   <= '0;
      sclk_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_LEAD;
          cnt    <= half_div;
          div_r  <= half_div;
          len_r  <= len_in;
          cpol_r <= cpol;
          cpha_r <= cpha;
          sel_r  <= sel_idx;
          sclk_r <= cpol;
          edge_n <= '0;
          rx_sh  <= '0;
          tx_sh  <= cpha ? {1'b0, aligned} : {aligned, 1'b0};
        end
        S_LEAD: begin
          cnt <= tick ? div_r : cnt - DIV_W'(1);
          if (tick) st <= S_SHIFT;
        end
        S_SHIFT: begin
          if (tick) begin
            cnt    <= div_r;
            sclk_r <= ~sclk_r;
            edge_n <= edge_n + EDGE_W'(1);
            if (sample_now) rx_sh <= {rx_sh[MAX_LEN-2:0], miso};
            else            tx_sh <= {tx_sh[MAX_LEN-1:0], 1'b0};
            if (last_edge)  st <= S_TAIL;
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        default: begin
          cnt <= tick ? cnt : cnt - DIV_W'(1);
          if (tick) begin
            st     <= S_IDLE;
            done_r <= 1'b1;
            rx_r   <= rx_sh;
          end
        end
      endcase
    end
  end

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(~ss_n) == 1);
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ss_n) && $stable(len_r) && $stable(cpha_r) && $stable(div_r)));
  a_r5_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(sclk));
  a_r5_end_level: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclk == cpol_r));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_quiet_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LEAD || st == S_TAIL) |=> $stable(sclk));
endmodule

// File: tb/spi_xfer_master_tb.sv
`timescale 1ns/1ps
module spi_xfer_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] tx_word = '0;
  logic [4:0]  char_len = 5'd8;
  logic        cpol = 1'b0, cpha = 1'b0;
  logic [1:0]  sel_idx = '0;
  logic [7:0]  half_div = '0;
  logic        busy, done, sclk, mosi;
  logic        miso = 1'b0;
  logic [15:0] rx_word;
  logic [3:0]  ss_n;

  int total = 0, fails = 0, cycles = 0;

  logic        exp_cpol = 1'b0, exp_cpha = 1'b0;
  logic [1:0]  exp_sel = '0;
  int          exp_len = 8, exp_h = 1;
  logic [15:0] slave_word = '0, cap = '0;
  logic [3:0]  act = '0, prev_act = '0;
  logic        prev_sclk = 1'b0, sel_bad = 1'b0, gap_bad = 1'b0;
  int          since = 0, edges = 0, sb = 0, lead_gap = 0, tail_gap = 0;

  spi_xfer_master dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .char_len(char_len),
    .cpol(cpol), .cpha(cpha), .sel_idx(sel_idx), .half_div(half_div), .busy(busy),
    .done(done), .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  always @(negedge clk) begin
    act = ~ss_n;
    if (act != 0) begin
      if (prev_act == 0) begin
        since = 0; edges = 0; sb = 0; cap = '0;
        if (act != (4'b1 << exp_sel)) sel_bad = 1'b1;
        if (!exp_cpha) begin miso = slave_word[exp_len-1]; sb = 1; end
      end else begin
        since++;
        if (act != (4'b1 << exp_sel)) sel_bad = 1'b1;
        if (sclk != prev_sclk) begin
          if (edges == 0) lead_gap = since;
          else if (since != exp_h) gap_bad = 1'b1;
          since = 0; edges++;
          if ((sclk != exp_cpol) != exp_cpha) cap = {cap[14:0], mosi};
          else if (sb < exp_len) begin miso = slave_word[exp_len-1-sb]; sb++; end
        end
      end
    end else if (prev_act != 0) begin
      tail_gap = since + 1;
    end
    prev_act = act;
    prev_sclk = sclk;
  end

  task automatic setup(input logic [15:0] tx, input int lf, input bit pol, input bit pha,
                       input logic [1:0] sel, input int dv, input logic [15:0] sw);
    exp_len = (lf < 4) ? 4 : (lf > 16) ? 16 : lf;
    exp_cpol = pol; exp_cpha = pha; exp_sel = sel; exp_h = dv + 1;
    slave_word = sw; sel_bad = 1'b0; gap_bad = 1'b0;
    tx_word = tx; char_len = 5'(lf); cpol = pol; cpha = pha; sel_idx = sel; half_div = 8'(dv);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic xfer(input logic [15:0] tx, input int lf, input bit pol, input bit pha,
                      input logic [1:0] sel, input int dv, input logic [15:0] sw, input bit poke);
    int mask;
    @(negedge clk);
    setup(tx, lf, pol, pha, sel, dv, sw);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy == 1'b1, "R8 busy before poke", int'(busy), 1);
      tx_word = ~tx; char_len = 5'd7; cpol = ~pol; cpha = ~pha;
      sel_idx = sel + 2'd1; half_div = 8'(dv + 3); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    mask = (1 << exp_len) - 1;
    chk(int'(rx_word) == (int'(sw) & mask), "R4 R7 rx_word", int'(rx_word), int'(sw) & mask);
    @(negedge clk); #1;
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
    chk(sclk == pol, "R5 sclk rest level", int'(sclk), int'(pol));
    chk(ss_n == 4'hF && !busy, "R8 no extra transfer, selects released", int'(ss_n), 15);
    chk(edges == 2 * exp_len, "R3 edge count", edges, 2 * exp_len);
    chk(int'(cap) == (int'(tx) & mask), "R3 R4 slave saw mosi MSB first", int'(cap), int'(tx) & mask);
    chk(!gap_bad, "R6 half period", int'(gap_bad), 0);
    chk(lead_gap >= exp_h && tail_gap >= exp_h, "R6 lead/tail margin", lead_gap, exp_h);
    chk(!sel_bad, "R2 only chosen select low", int'(sel_bad), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 idle flags", int'({busy, done}), 0);
    chk(ss_n == 4'hF, "R1 selects high", int'(ss_n), 15);
    chk(sclk == 0 && mosi == 0, "R1 sclk/mosi low", int'({sclk, mosi}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && ss_n == 4'hF, "R1 idle after reset release", int'(ss_n), 15);

    for (int m = 0; m < 4; m++)
      for (int l = 4; l <= 16; l++)
        for (int d = 0; d <= 2; d += 2) begin
          logic [15:0] tx, sw;
          tx = 16'(l * 4391 + m * 733 + d * 97) ^ 16'hA5C3;
          sw = 16'(l * 2719 + m * 131 + d * 53) ^ 16'h3C96;
          xfer(tx, l, m[1], m[0], 2'(l + m), d, sw, 1'b0);
        end

    // R3: lengths outside range are clamped
    xfer(16'hFFFF, 0,  1'b0, 1'b0, 2'd1, 1, 16'h0009, 1'b0);
    xfer(16'h000D, 2,  1'b1, 1'b1, 2'd2, 0, 16'hFFF6, 1'b0);
    xfer(16'hBEEF, 20, 1'b0, 1'b1, 2'd3, 1, 16'h1357, 1'b0);
    xfer(16'h8001, 31, 1'b1, 1'b0, 2'd0, 0, 16'h7FFE, 1'b0);

    // R8: inputs and start disturbed during each mode
    for (int m = 0; m < 4; m++)
      xfer(16'h5A3C ^ 16'(m * 257), 12, m[1], m[0], 2'(m), 1, 16'hC3A5 ^ 16'(m * 17), 1'b1);

    // R9: start held through done
    @(negedge clk);
    setup(16'h00A7, 8, 1'b1, 1'b0, 2'd2, 1, 16'h005E);
    start = 1'b1;
    wait_done();
    chk(rx_word == 16'h005E, "R9 first rx", int'(rx_word), 16'h5E);
    tx_word = 16'h0033; slave_word = 16'h00C9; gap_bad = 1'b0;
    @(negedge clk); #1;
    chk(busy == 1'b1, "R9 restart next cycle", int'(busy), 1);
    chk(ss_n == 4'b1011, "R9 select reasserted", int'(ss_n), 11);
    start = 1'b0;
    wait_done();
    chk(rx_word == 16'h00C9, "R9 second rx", int'(rx_word), 16'hC9);
    @(negedge clk); #1;
    chk(cap == 16'h0033 && !gap_bad, "R9 second tx", int'(cap), 16'h33);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule